// File: doc/BRIEF.md
# AES-128 Round-Key Precompute Engine

This block fills a key memory ahead of time so that a compact AES-128 datapath never has to expand keys while it ciphers. After a start pulse it expands the captured 128-bit cipher key at one 32-bit word per cycle. The forward pass takes 44 cycles. Each word goes to the encryption region of an external dual-port RAM through port A. In the same cycle, port B writes the byte-wise S-box image of that word into a scratch region. The block computes only one set of four S-boxes. The S-box image a cycle stores is also the substituted word that the next `w0` needs.

When decryption keys are requested, a second pass of 48 cycles follows. It reads the scratch images back through port A and undoes the substitution with four inverse S-boxes. It then applies InvMixColumn to the words of inverse rounds 1 to 9 and writes the keys for the equivalent inverse cipher through port B. Inverse round `i` takes round `10-i`, so the keys are stored in reversed round order. Inverse rounds 0 and 10 are the plain round keys 10 and 0. The block never runs while the cipher runs, so the RAM ports are free for it.

Word addressing: column `c` of round `r` is word `4r+c`. Default bases are 0 for the encryption region, 64 for the inverse region and 128 for the scratch region.

Top module: `aes_key_prep`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `a_we_o` and `b_we_o` are low.
- R2: A start in idle produces 44 port-A writes on consecutive cycles, to addresses ENC_BASE+0 up to ENC_BASE+43 in increasing order. Word 4r is p0 ^ Rot(Sub(p3)) ^ {rcon_r,00,00,00}, where Rot turns bytes [a0,a1,a2,a3] (a0 in bits 31:24) into [a1,a2,a3,a0]. rcon starts at 01 and is doubled modulo x^8+x^4+x^3+x+1 each round. Words 4r+1 to 4r+3 are each the previous word XOR the word four places back.
- R3: Words 0 to 3 are the cipher key, with `key_i[127:96]` as word 0.
- R4: Each port-A write is paired, in the same cycle, with a port-B write of the byte-wise S-box of the same word to address SCR_BASE + (word index).
- R5: With the request set, address INV_BASE+4i+c (i = 1 to 9) receives InvMixColumn (coefficients 0E, 0B, 0D, 09 on the row order) of round key 10-i, column c.
- R6: With the request set, inverse round 0 holds round key 10 and inverse round 10 holds round key 0, both without InvMixColumn.
- R7: Port A never writes during the inverse pass. It only supplies read addresses of the scratch region.
- R8: `done_o` is a one-cycle pulse. It is seen 44 clock edges after the edge that samples start without the request, and 92 edges after it with the request.
- R9: A start pulse while a run is in progress has no effect on the key, the request, the written words or the done timing.
- R10: Without the request, no write reaches the inverse region.
- R11: The request is sampled together with start. Changing it later in the run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled in idle only |
| inv_req_i | input | 1 | Also build the inverse-cipher keys, sampled with start |
| key_i | input | 128 | Cipher key, word 0 in bits 127:96 |
| a_we_o | output | 1 | Port A write enable |
| a_addr_o | output | ADDR_W (8) | Port A address (write or read) |
| a_wdata_o | output | 32 | Port A write data |
| a_rdata_i | input | 32 | Port A read data, one cycle after the address |
| b_we_o | output | 1 | Port B write enable |
| b_addr_o | output | ADDR_W (8) | Port B write address |
| b_wdata_o | output | 32 | Port B write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Several internal faults show at the ports right away. A wrong rcon register, or a wrong window of the last four words, corrupts the first word of the next round. That word and every later one differ in the memory, so one fault spoils up to 40 encryption words and all their scratch and inverse copies. A read address or pipeline tag that is off by one in the inverse pass moves or swaps whole columns within the inverse region. Applying or skipping InvMixColumn on the wrong round changes exactly the four words of inverse round 0, 10 or a middle round. A fault in the counter or state register moves the done pulse away from edge 44 or 92, or changes the number of write strobes. The bench compares every word of all three regions and counts strobes and cycles after each run.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
   localparam int WORD_W        = 32;
   localparam int WORDS_PER_KEY = 4;
   localparam int ROUNDS        = 10;
   localparam int KEY_WORDS     = WORDS_PER_KEY * (ROUNDS + 1);
   localparam int INV_LATENCY   = 4;
   localparam int INV_CYCLES    = KEY_WORDS + INV_LATENCY;

   typedef logic [7:0]        byte_t;
   typedef logic [WORD_W-1:0] word_t;
   typedef enum logic [1:0] {KS_IDLE, KS_FWD, KS_INV} ks_state_e;

   function automatic byte_t gf_xtime(byte_t a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic byte_t gf_mul(byte_t a, byte_t b);
      byte_t acc = 8'h00;
      byte_t x   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ x;
         x = gf_xtime(x);
      end
      return acc;
   endfunction

   // a^254 is the multiplicative inverse; zero maps to zero
   function automatic byte_t gf_inv(byte_t a);
      byte_t r  = 8'h01;
      byte_t sq = a;
      for (int i = 1; i < 8; i++) begin
         sq = gf_mul(sq, sq);
         r  = gf_mul(r, sq);
      end
      return r;
   endfunction

   function automatic byte_t rotl8(byte_t a, int n);
      logic [15:0] t;
      t = {a, a} << n;
      return t[15:8];
   endfunction

   function automatic byte_t sbox_fwd(byte_t a);
      byte_t b = gf_inv(a);
      return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
   endfunction

   function automatic byte_t sbox_rev(byte_t a);
      byte_t b = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
      return gf_inv(b);
   endfunction

   function automatic bit regions_clash(int x, int y);
      return (x < y + KEY_WORDS) && (y < x + KEY_WORDS);
   endfunction
endpackage

// File: rtl/ks_sbox_word.sv
module ks_sbox_word
   import aes_ks_pkg::*;
#(
   parameter bit INVERSE = 1'b0
) (
   input  word_t din,
   output word_t dout
);
   for (genvar g = 0; g < WORDS_PER_KEY; g++) begin : g_byte
      if (INVERSE) begin : g_rev
         assign dout[8*g +: 8] = sbox_rev(din[8*g +: 8]);
      end else begin : g_fwd
         assign dout[8*g +: 8] = sbox_fwd(din[8*g +: 8]);
      end
   end
endmodule

// File: rtl/ks_inv_mix.sv
module ks_inv_mix
   import aes_ks_pkg::*;
(
   input  word_t col_i,
   output word_t col_o
);
   localparam byte_t COEF [4] = '{8'h0e, 8'h0b, 8'h0d, 8'h09};

   for (genvar r = 0; r < 4; r++) begin : g_row
      assign col_o[31-8*r -: 8] = gf_mul(COEF[(4-r)%4], col_i[31:24])
                                ^ gf_mul(COEF[(5-r)%4], col_i[23:16])
                                ^ gf_mul(COEF[(6-r)%4], col_i[15:8])
                                ^ gf_mul(COEF[(7-r)%4], col_i[7:0]);
   end
endmodule

// File: rtl/aes_key_prep.sv
module aes_key_prep
   import aes_ks_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int ENC_BASE = 0,
   parameter int INV_BASE = 64,
   parameter int SCR_BASE = 128,
   parameter bit INV_PASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              inv_req_i,
   input  logic [127:0]      key_i,
   output logic              a_we_o,
   output logic [ADDR_W-1:0] a_addr_o,
   output logic [31:0]       a_wdata_o,
   input  logic [31:0]       a_rdata_i,
   output logic              b_we_o,
   output logic [ADDR_W-1:0] b_addr_o,
   output logic [31:0]       b_wdata_o,
   output logic              done_o
);
   localparam int CNT_W = $clog2(INV_CYCLES);
   localparam logic [ADDR_W-1:0] ENC_A   = ADDR_W'(ENC_BASE);
   localparam logic [ADDR_W-1:0] INV_A   = ADDR_W'(INV_BASE);
   localparam logic [ADDR_W-1:0] SCR_TOP = ADDR_W'(SCR_BASE + KEY_WORDS - WORDS_PER_KEY);
   localparam logic [ADDR_W-1:0] SCR_A   = ADDR_W'(SCR_BASE);

   if (SCR_BASE + KEY_WORDS > 2**ADDR_W || INV_BASE + KEY_WORDS > 2**ADDR_W
       || ENC_BASE + KEY_WORDS > 2**ADDR_W) begin : g_bad_depth
      $fatal(1, "key regions exceed the address space");
   end
   if (regions_clash(ENC_BASE, INV_BASE) || regions_clash(ENC_BASE, SCR_BASE)
       || regions_clash(INV_BASE, SCR_BASE)) begin : g_bad_layout
      $fatal(1, "key regions overlap");
   end
   if (ADDR_W < CNT_W) begin : g_bad_width
      $fatal(1, "address width below counter width");
   end

   ks_state_e          state_q;
   logic [CNT_W-1:0]   cnt_q;
   word_t              key_q [WORDS_PER_KEY];
   word_t              win_q [WORDS_PER_KEY];
   byte_t              rcon_q;
   logic               inv_q;
   logic               a_we_q, b_we_q, done_q;
   logic [ADDR_W-1:0]  a_addr_q, b_addr_q;
   word_t              a_wdata_q, b_wdata_q;
   logic               p1_v, p2_v;
   logic [CNT_W-1:0]   p1_idx, p2_idx;

   word_t fresh_w, fresh_sb, rot_sb, inv_w;
   logic [ADDR_W-1:0] src_addr;

   // forward expansion: the S-box image stored last cycle doubles as Sub(p3)
   always_comb begin
      rot_sb = {b_wdata_q[23:0], b_wdata_q[31:24]};
      if (cnt_q < CNT_W'(WORDS_PER_KEY))
         fresh_w = key_q[cnt_q[1:0]];
      else if (cnt_q[1:0] == 2'b00)
         fresh_w = win_q[0] ^ rot_sb ^ {rcon_q, 24'h000000};
      else
         fresh_w = win_q[0] ^ win_q[WORDS_PER_KEY-1];
   end

   ks_sbox_word #(.INVERSE(1'b0)) u_fwd_sbox (.din(fresh_w), .dout(fresh_sb));

   // inverse word k reads the scratch image of round (ROUNDS - k/4), same column
   assign src_addr = SCR_TOP - ADDR_W'({cnt_q[CNT_W-1:2], 2'b00}) + ADDR_W'(cnt_q[1:0]);

   logic take_inv;
   if (INV_PASS) begin : g_inv
      word_t isb_w, imc_w;
      logic  edge_round;
      ks_sbox_word #(.INVERSE(1'b1)) u_rev_sbox (.din(a_rdata_i), .dout(isb_w));
      ks_inv_mix u_imix (.col_i(isb_w), .col_o(imc_w));
      assign edge_round = (p2_idx[CNT_W-1:2] == '0)
                       || (p2_idx[CNT_W-1:2] == (CNT_W-2)'(ROUNDS));
      assign inv_w      = edge_round ? isb_w : imc_w;
      assign take_inv   = inv_req_i;
   end else begin : g_no_inv
      assign inv_w    = a_rdata_i & '0;
      assign take_inv = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= KS_IDLE;
         cnt_q     <= '0;
         rcon_q    <= 8'h01;
         inv_q     <= 1'b0;
         a_we_q    <= 1'b0;
         b_we_q    <= 1'b0;
         done_q    <= 1'b0;
         a_addr_q  <= '0;
         b_addr_q  <= '0;
         a_wdata_q <= '0;
         b_wdata_q <= '0;
         p1_v      <= 1'b0;
         p2_v      <= 1'b0;
         p1_idx    <= '0;
         p2_idx    <= '0;
         for (int i = 0; i < WORDS_PER_KEY; i++) begin
            key_q[i] <= '0;
            win_q[i] <= '0;
         end
      end else begin
         a_we_q <= 1'b0;
         b_we_q <= 1'b0;
         done_q <= 1'b0;
         p1_v   <= 1'b0;
         p2_v   <= p1_v;
         p2_idx <= p1_idx;
         unique case (state_q)
            KS_IDLE: if (start_i) begin
               state_q <= KS_FWD;
               cnt_q   <= '0;
               rcon_q  <= 8'h01;
               inv_q   <= take_inv;
               for (int i = 0; i < WORDS_PER_KEY; i++)
                  key_q[i] <= key_i[127-32*i -: 32];
            end
            KS_FWD: begin
               a_we_q    <= 1'b1;
               a_addr_q  <= ENC_A + ADDR_W'(cnt_q);
               a_wdata_q <= fresh_w;
               b_we_q    <= 1'b1;
               b_addr_q  <= SCR_A + ADDR_W'(cnt_q);
               b_wdata_q <= fresh_sb;
               for (int i = 0; i < WORDS_PER_KEY-1; i++) win_q[i] <= win_q[i+1];
               win_q[WORDS_PER_KEY-1] <= fresh_w;
               if (cnt_q >= CNT_W'(WORDS_PER_KEY) && cnt_q[1:0] == 2'b00)
                  rcon_q <= gf_xtime(rcon_q);
               if (cnt_q == CNT_W'(KEY_WORDS-1)) begin
                  cnt_q <= '0;
                  if (inv_q) state_q <= KS_INV;
                  else begin
                     state_q <= KS_IDLE;
                     done_q  <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            KS_INV: begin
               if (cnt_q < CNT_W'(KEY_WORDS)) begin
                  a_addr_q <= src_addr;
                  p1_v     <= 1'b1;
                  p1_idx   <= cnt_q;
               end
               if (p2_v) begin
                  b_we_q    <= 1'b1;
                  b_addr_q  <= INV_A + ADDR_W'(p2_idx);
                  b_wdata_q <= inv_w;
               end
               if (cnt_q == CNT_W'(INV_CYCLES-1)) begin
                  state_q <= KS_IDLE;
                  cnt_q   <= '0;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= KS_IDLE;
         endcase
      end
   end

   assign a_we_o    = a_we_q;
   assign a_addr_o  = a_addr_q;
   assign a_wdata_o = a_wdata_q;
   assign b_we_o    = b_we_q;
   assign b_addr_o  = b_addr_q;
   assign b_wdata_o = b_wdata_q;
   assign done_o    = done_q;
endmodule

// File: rtl/aes_key_prep_chk.sv
module aes_key_prep_chk
   import aes_ks_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int ENC_BASE = 0,
   parameter int INV_BASE = 64,
   parameter int SCR_BASE = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_we_o,
   input logic [ADDR_W-1:0] a_addr_o,
   input logic              b_we_o,
   input logic [ADDR_W-1:0] b_addr_o,
   input logic              done_o
);
   localparam logic [ADDR_W:0] ENC_LO = (ADDR_W+1)'(ENC_BASE);
   localparam logic [ADDR_W:0] ENC_HI = (ADDR_W+1)'(ENC_BASE + KEY_WORDS);
   localparam logic [ADDR_W:0] INV_LO = (ADDR_W+1)'(INV_BASE);
   localparam logic [ADDR_W:0] INV_HI = (ADDR_W+1)'(INV_BASE + KEY_WORDS);
   localparam logic [ADDR_W-1:0] ENC_A = ADDR_W'(ENC_BASE);
   localparam logic [ADDR_W-1:0] SCR_A = ADDR_W'(SCR_BASE);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8
   AST_ENC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      a_we_o |-> ({1'b0, a_addr_o} >= ENC_LO && {1'b0, a_addr_o} < ENC_HI)); // R2
   AST_ENC_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we_o && $past(a_we_o)) |-> a_addr_o == $past(a_addr_o) + 1'b1); // R2
   AST_SBOX_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      a_we_o |-> (b_we_o && b_addr_o == a_addr_o - ENC_A + SCR_A)); // R4
   AST_INV_PORT_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (b_we_o && {1'b0, b_addr_o} >= INV_LO && {1'b0, b_addr_o} < INV_HI) |-> !a_we_o); // R7
   AST_NO_WRITE_AT_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !a_we_o); // R8
endmodule

bind aes_key_prep aes_key_prep_chk #(
   .ADDR_W(ADDR_W), .ENC_BASE(ENC_BASE), .INV_BASE(INV_BASE), .SCR_BASE(SCR_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .a_we_o(a_we_o), .a_addr_o(a_addr_o),
   .b_we_o(b_we_o), .b_addr_o(b_addr_o), .done_o(done_o)
);

// File: tb/aes_key_prep_tb_top.sv
`timescale 1ns/1ps
module aes_key_prep_tb_top;
   localparam int NV = 4;
   // {request, key}
   localparam logic [128:0] VEC [NV] = '{
      {1'b1, 128'h2b7e151628aed2a6abf7158809cf4f3c},
      {1'b1, 128'h000102030405060708090a0b0c0d0e0f},
      {1'b0, 128'hffffffffffffffffffffffffffffffff},
      {1'b1, 128'h00000000000000000000000000000000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic inv_req = 1'b0;
   logic [127:0] key = '0;
   logic a_we, b_we, done;
   logic [7:0] a_addr, b_addr;
   logic [31:0] a_wdata, b_wdata;
   logic [31:0] a_rdata;

   always #4 clk = ~clk;

   aes_key_prep dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .inv_req_i(inv_req), .key_i(key),
      .a_we_o(a_we), .a_addr_o(a_addr), .a_wdata_o(a_wdata), .a_rdata_i(a_rdata),
      .b_we_o(b_we), .b_addr_o(b_addr), .b_wdata_o(b_wdata), .done_o(done)
   );

   // dual-port RAM model, read-before-write on port A
   logic [31:0] mem [256];
   int a_writes = 0, b_writes = 0, inv_writes = 0;
   always @(posedge clk) begin
      a_rdata <= mem[a_addr];
      if (a_we) begin mem[a_addr] <= a_wdata; a_writes <= a_writes + 1; end
      if (b_we) begin
         mem[b_addr] <= b_wdata;
         b_writes <= b_writes + 1;
         if (b_addr >= 8'd64 && b_addr < 8'd108) inv_writes <= inv_writes + 1;
      end
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // independent reference model
   logic [7:0] sb [256];
   logic [7:0] isb [256];
   logic [31:0] exp_enc [44];
   logic [31:0] exp_inv [44];

   function automatic logic [7:0] m(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 8'h00;
      for (int i = 7; i >= 0; i--) begin
         p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
         if (b[i]) p = p ^ a;
      end
      return p;
   endfunction

   function automatic logic [31:0] sub_w(input logic [31:0] w);
      return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
   endfunction

   function automatic logic [31:0] imc(input logic [31:0] w);
      logic [7:0] a0 = w[31:24], a1 = w[23:16], a2 = w[15:8], a3 = w[7:0];
      return {m(a0,8'h0e)^m(a1,8'h0b)^m(a2,8'h0d)^m(a3,8'h09),
              m(a0,8'h09)^m(a1,8'h0e)^m(a2,8'h0b)^m(a3,8'h0d),
              m(a0,8'h0d)^m(a1,8'h09)^m(a2,8'h0e)^m(a3,8'h0b),
              m(a0,8'h0b)^m(a1,8'h0d)^m(a2,8'h09)^m(a3,8'h0e)};
   endfunction

   task automatic build_tables();
      for (int x = 0; x < 256; x++) begin
         logic [7:0] b = 8'h00;
         logic [7:0] s;
         for (int y = 1; y < 256; y++) if (m(8'(x), 8'(y)) == 8'h01) b = 8'(y);
         for (int i = 0; i < 8; i++)
            s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
         sb[x] = s;
         isb[s] = 8'(x);
      end
   endtask

   task automatic expand(input logic [127:0] k);
      logic [7:0] rc = 8'h01;
      for (int i = 0; i < 4; i++) exp_enc[i] = k[127-32*i -: 32];
      for (int i = 4; i < 44; i++) begin
         if (i % 4 == 0) begin
            logic [31:0] t = sub_w(exp_enc[i-1]);
            exp_enc[i] = exp_enc[i-4] ^ {t[23:0], t[31:24]} ^ {rc, 24'h0};
            rc = m(rc, 8'h02);
         end else exp_enc[i] = exp_enc[i-4] ^ exp_enc[i-1];
      end
      for (int r = 0; r < 11; r++)
         for (int c = 0; c < 4; c++)
            exp_inv[4*r+c] = (r == 0 || r == 10) ? exp_enc[4*(10-r)+c] : imc(exp_enc[4*(10-r)+c]);
   endtask

   // start a run; optionally poke start with another key mid-run
   task automatic run_key(input logic [127:0] k, input logic req, input int poke_at,
                          output int cyc, output int da, output int db, output int di);
      int a0 = a_writes, b0 = b_writes, i0 = inv_writes;
      @(negedge clk);
      key = k; inv_req = req; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0; inv_req = ~req; key = ~k;   // R11: late changes must not matter
      cyc = 0;
      while (!done && cyc < 300) begin
         if (cyc == poke_at) begin start = 1'b1; key = 128'h0123456789abcdef0011223344556677; inv_req = ~req; end
         else start = 1'b0;
         @(posedge clk); @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      @(posedge clk); @(negedge clk);
      check(done == 1'b0, "R8", "done lasts one cycle", 128'(done), 128'h0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      da = a_writes - a0; db = b_writes - b0; di = inv_writes - i0;
   endtask

   task automatic verify(input logic [127:0] k, input logic req, input int cyc,
                         input int da, input int db, input int di, input string tag);
      int bad;
      expand(k);
      check(cyc == (req ? 92 : 44), "R8", {tag, " cycles start to done"}, 128'(cyc), 128'(req ? 92 : 44));
      check(da == 44, "R2", {tag, " port A write count"}, 128'(da), 128'd44);
      check(db == (req ? 88 : 44), "R7", {tag, " port B write count"}, 128'(db), 128'(req ? 88 : 44));
      check(di == (req ? 44 : 0), "R10", {tag, " inverse region writes"}, 128'(di), 128'(req ? 44 : 0));
      for (int i = 0; i < 4; i++)
         check(mem[i] == k[127-32*i -: 32], "R3", {tag, " round 0 word"}, 128'(mem[i]), 128'(k[127-32*i -: 32]));
      bad = 0;
      for (int i = 0; i < 44; i++) if (mem[i] !== exp_enc[i]) begin
         if (bad == 0) check(1'b0, "R2", {tag, " encryption word"}, 128'(mem[i]), 128'(exp_enc[i]));
         bad++;
      end
      if (bad == 0) check(1'b1, "R2", "", 0, 0);
      bad = 0;
      for (int i = 0; i < 44; i++) if (mem[128+i] !== sub_w(exp_enc[i])) begin
         if (bad == 0) check(1'b0, "R4", {tag, " scratch S-box image"}, 128'(mem[128+i]), 128'(sub_w(exp_enc[i])));
         bad++;
      end
      if (bad == 0) check(1'b1, "R4", "", 0, 0);
      if (req) begin
         bad = 0;
         for (int i = 4; i < 40; i++) if (mem[64+i] !== exp_inv[i]) begin
            if (bad == 0) check(1'b0, "R5", {tag, " mixed inverse word"}, 128'(mem[64+i]), 128'(exp_inv[i]));
            bad++;
         end
         if (bad == 0) check(1'b1, "R5", "", 0, 0);
         for (int c = 0; c < 4; c++) begin
            check(mem[64+c] == exp_enc[40+c], "R6", {tag, " inverse round 0"}, 128'(mem[64+c]), 128'(exp_enc[40+c]));
            check(mem[104+c] == exp_enc[c], "R6", {tag, " inverse round 10"}, 128'(mem[104+c]), 128'(exp_enc[c]));
         end
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      int cyc, da, db, di;
      build_tables();
      repeat (3) @(negedge clk);
      check(done == 1'b0 && a_we == 1'b0 && b_we == 1'b0, "R1", "outputs in reset",
            128'({done, a_we, b_we}), 128'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done == 1'b0 && a_we == 1'b0 && b_we == 1'b0, "R1", "outputs after reset",
            128'({done, a_we, b_we}), 128'h0);

      for (int v = 0; v < NV; v++) begin
         run_key(VEC[v][127:0], VEC[v][128], -1, cyc, da, db, di);
         verify(VEC[v][127:0], VEC[v][128], cyc, da, db, di, $sformatf("vec%0d", v));
         if (v == 0) begin
            check(mem[4] == 32'ha0fafe17, "R2", "known word 4", 128'(mem[4]), 128'h a0fafe17);
            check(mem[43] == 32'hb6630ca6, "R2", "known word 43", 128'(mem[43]), 128'hb6630ca6);
            check(mem[64] == 32'hd014f9a8, "R6", "known inverse word 0", 128'(mem[64]), 128'hd014f9a8);
         end
         if (v == 1)
            check(mem[40] == 32'h13111d7f, "R2", "known word 40", 128'(mem[40]), 128'h13111d7f);
      end

      // R9: start with another key while busy, in both passes
      run_key(VEC[0][127:0], 1'b1, 10, cyc, da, db, di);
      verify(VEC[0][127:0], 1'b1, cyc, da, db, di, "R9 fwd poke");
      run_key(VEC[1][127:0], 1'b1, 60, cyc, da, db, di);
      verify(VEC[1][127:0], 1'b1, cyc, da, db, di, "R9 inv poke");
      // R11: request set at start but dropped during the run still builds inverse keys (covered by run_key)
      run_key(VEC[3][127:0], 1'b0, -1, cyc, da, db, di);
      verify(VEC[3][127:0], 1'b0, cyc, da, db, di, "R11 late request");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule